// File: doc/BRIEF.md
# Radix-4 Booth Carry-Save Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit signed product. The multiplier operand is recoded in radix 4. Each overlapping three-bit window picks one addend from {0, +A, +2A, -2A, -A}. This gives about N/2 partial-product rows instead of N. The rows are then compressed by levels of 3:2 carry-save adders. At each level, every full group of three rows becomes a sum row and a carry row. The zero, one or two rows left over go straight on to the next level. The process stops when two rows remain, and one carry-propagate adder adds them.

Both operands are captured in input registers and the product is held in an output register. The latency is therefore fixed at two clock edges, and a new operand pair can be accepted on every cycle. Reset is synchronous and active low, and it clears all three registers.

Top module: `booth_csa_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge, the operand and product registers clear. `product` reads 0 after that edge, and it still reads 0 after the first edge with `rst_n` high again, because the cleared operands are multiplied.
- R2: Operands applied before rising edge k give `product` equal to the low 2N bits of their signed product, visible right after edge k+1.
- R3: A new operand pair can be applied on every cycle. Each pair yields its own result, in order of arrival, with no idle cycles.
- R4: The most negative value times itself gives 2^(2N-2), which is positive. For N=16 this is 0x40000000.
- R5: A zero on either operand gives a zero product.
- R6: An operand of -1 gives the negation of the other operand. This includes -1 times the most negative value, which is +2^(N-1).
- R7: Window i takes multiplier bits [2i+1], [2i] and [2i-1], with bit -1 equal to 0. The window value maps as follows: 000 and 111 select 0, 001 and 010 select +A, 011 selects +2A, 100 selects -2A, 101 and 110 select -A. A negative addend is formed as the inverted row plus a 1 at bit 2i. Multiplier patterns that use every code (0x5555, 0xAAAA, 0x3333, 0xCCCC, 0x7FFF, 0x8000) give exact products.
- R8: When both operands are nonzero, the top bit of `product` equals the XOR of the operands' sign bits.
- R9: For an odd N, the multiplier is sign-extended to a whole number of windows. Every operand pair for N=5 gives the exact 10-bit signed product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | N | Multiplicand, two's complement |
| opnd_b | input | N | Multiplier (Booth-recoded), two's complement |
| product | output | 2N | Signed product, registered |

## Verification
Some internal faults show up only for certain operands. A wrong recoding entry, a missing negation injection or a misaligned carry row shifts the sum by a power of two. This appears at `product` two edges after the affected operand pair, and only for multiplier patterns that use that window code. Corner operands and the code-covering patterns expose it at once. A fault in the leftover-row pass-through or the sign extension shows up for the upper windows and for odd widths. The exhaustive small-width sweep catches it within the first few dozen pairs.

// File: rtl/booth_pkg.sv
// Shared types and helpers for the radix-4 Booth multiplier.
// Assumes: callers pass a three-bit multiplier window, low bit = bit 2i-1.
package booth_pkg;

    // Addend selection for one window: magnitude choice and sign.
    typedef struct packed {
        logic neg;  // addend is negated
        logic one;  // magnitude is A
        logic two;  // magnitude is 2A
    } booth_sel_t;

    // Map a three-bit window onto an addend selection.
    function automatic booth_sel_t booth_decode(input logic [2:0] win);
        booth_sel_t s;
        s = '0;
        case (win)
            3'b001, 3'b010: s.one = 1'b1;
            3'b011:         s.two = 1'b1;
            3'b100:         begin s.two = 1'b1; s.neg = 1'b1; end
            3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
            default:        s = '0;   // 000 and 111 select zero
        endcase
        return s;
    endfunction

    // Rows left after one 3:2 level acting on r rows.
    function automatic int csa_next_rows(input int r);
        return 2 * (r / 3) + (r % 3);
    endfunction

endpackage

// File: rtl/csa_row.sv
// One 3:2 carry-save level of width W: a full adder for each bit column.
// The carry row is returned already shifted one place left; the carry
// out of the top column is dropped (products are taken modulo 2^W).
module csa_row #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    assign carry_o[0] = 1'b0;

    // Per-column full adders.
    for (genvar k = 0; k < W; k++) begin : g_col
        assign sum_o[k] = x_i[k] ^ y_i[k] ^ z_i[k];
        if (k < W - 1) begin : g_cy
            assign carry_o[k+1] = (x_i[k] & y_i[k]) | (x_i[k] & z_i[k]) | (y_i[k] & z_i[k]);
        end
    end

endmodule

// File: rtl/csa_reduce.sv
// Recursive carry-save reduction of ROWS rows of width W down to two rows.
// Each level compresses full groups of three rows and forwards the
// zero, one or two leftover rows unchanged to the next level.
// Assumes: ROWS >= 1; rows are packed with row r at bits [r*W +: W].
module csa_reduce #(
    parameter int W    = 32,
    parameter int ROWS = 9
) (
    input  logic [ROWS*W-1:0] rows_i,
    output logic [W-1:0]      sum_o,
    output logic [W-1:0]      carry_o
);
    import booth_pkg::*;

    if (ROWS == 1) begin : g_one
        assign sum_o   = rows_i;
        assign carry_o = '0;
    end else if (ROWS == 2) begin : g_two
        assign sum_o   = rows_i[W-1:0];
        assign carry_o = rows_i[2*W-1:W];
    end else begin : g_level
        localparam int NGRP = ROWS / 3;
        localparam int NREM = ROWS % 3;
        localparam int NXT  = csa_next_rows(ROWS);

        logic [NXT*W-1:0] nxt;

        // Full groups of three rows into adder arrays.
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            csa_row #(.W(W)) u_row (
                .x_i    (rows_i[(3*g)*W +: W]),
                .y_i    (rows_i[(3*g+1)*W +: W]),
                .z_i    (rows_i[(3*g+2)*W +: W]),
                .sum_o  (nxt[(2*g)*W +: W]),
                .carry_o(nxt[(2*g+1)*W +: W])
            );
        end

        // Leftover rows bypass this level.
        for (genvar r = 0; r < NREM; r++) begin : g_pass
            assign nxt[(2*NGRP+r)*W +: W] = rows_i[(3*NGRP+r)*W +: W];
        end

        csa_reduce #(.W(W), .ROWS(NXT)) u_next (
            .rows_i (nxt),
            .sum_o  (sum_o),
            .carry_o(carry_o)
        );
    end

endmodule

// File: rtl/booth_pp_gen.sv
// Radix-4 Booth partial-product generator.
// Produces G = ceil(N/2) rows of width 2N, row i holding the selected
// addend sign-extended and shifted left by 2i, plus one correction row
// carrying the +1 of each negated row at bit 2i.
// Assumes: both operands are two's complement; bit -1 of b is 0.
module booth_pp_gen #(
    parameter int N = 16
) (
    input  logic [N-1:0]                     a_i,
    input  logic [N-1:0]                     b_i,
    output logic [(((N+1)/2)+1)*(2*N)-1:0]   rows_o
);
    import booth_pkg::*;

    localparam int W  = 2 * N;
    localparam int G  = (N + 1) / 2;
    localparam int BX = 2 * G;

    logic [BX-1:0] b_sx;
    logic [BX:0]   b_ext;
    logic [W-1:0]  a_one;
    logic [W-1:0]  a_two;
    logic [W-1:0]  corr;
    booth_sel_t    sel [G];

    assign b_sx  = BX'(signed'(b_i));
    assign b_ext = {b_sx, 1'b0};
    assign a_one = W'(signed'(a_i));
    assign a_two = {a_one[W-2:0], 1'b0};

    // One selected and shifted addend per window.
    for (genvar i = 0; i < G; i++) begin : g_win
        localparam int SH = 2 * i;
        logic [W-1:0] mag;
        logic [W-1:0] signed_mag;

        assign sel[i]     = booth_decode(b_ext[SH+2:SH]);
        assign mag        = sel[i].two ? a_two : (sel[i].one ? a_one : '0);
        assign signed_mag = sel[i].neg ? ~mag : mag;
        assign rows_o[i*W +: W] = signed_mag << SH;
    end

    // Collect the +1 of every negated row into the correction row.
    always_comb begin
        corr = '0;
        for (int i = 0; i < G; i++) begin
            corr[2*i] = sel[i].neg;
        end
    end

    assign rows_o[G*W +: W] = corr;

endmodule

// File: rtl/booth_csa_mult.sv
// Registered signed multiplier: operand registers, Booth recoding,
// carry-save reduction, one carry-propagate adder, product register.
// Latency two rising edges; one new operand pair accepted per cycle.
// Assumes: synchronous active-low reset; N >= 2.
module booth_csa_mult #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   opnd_a,
    input  logic [N-1:0]   opnd_b,
    output logic [2*N-1:0] product
);

    localparam int W    = 2 * N;
    localparam int G    = (N + 1) / 2;
    localparam int ROWS = G + 1;

    logic [N-1:0]      a_q;
    logic [N-1:0]      b_q;
    logic [ROWS*W-1:0] pp_rows;
    logic [W-1:0]      red_sum;
    logic [W-1:0]      red_carry;
    logic [W-1:0]      full_sum;

    // Capture the operands for this cycle's multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= opnd_a;
            b_q <= opnd_b;
        end
    end

    booth_pp_gen #(.N(N)) u_ppgen (
        .a_i   (a_q),
        .b_i   (b_q),
        .rows_o(pp_rows)
    );

    csa_reduce #(.W(W), .ROWS(ROWS)) u_tree (
        .rows_i (pp_rows),
        .sum_o  (red_sum),
        .carry_o(red_carry)
    );

    assign full_sum = red_sum + red_carry;

    // Hold the finished product for the consumer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product <= '0;
        end else begin
            product <= full_sum;
        end
    end

endmodule

// File: rtl/booth_csa_mult_chk.sv
// Port-level property checker for booth_csa_mult, bound to every instance.
// Assumes: the bound instance's N matches this checker's N.
module booth_csa_mult_chk #(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   opnd_a,
    input logic [N-1:0]   opnd_b,
    input logic [2*N-1:0] product
);

    localparam int W = 2 * N;

    logic [1:0] seen;

    // Count clean edges since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [W-1:0] xs;
        logic [W-1:0] ys;
        xs = W'(signed'(x));
        ys = W'(signed'(y));
        return xs * ys;
    endfunction

    // R1: reset clears the product register.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> product == '0);

    // R2: value and two-edge latency.
    a_r2_product_value: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> product == ref_mul($past(opnd_a, 2), $past(opnd_b, 2)));

    // R3: a repeated operand pair leaves the product unchanged.
    a_r3_steady_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && $past(opnd_a, 2) == $past(opnd_a, 3)
                      && $past(opnd_b, 2) == $past(opnd_b, 3)) |-> $stable(product));

    // R5: zero operand gives zero.
    a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && ($past(opnd_a, 2) == '0 || $past(opnd_b, 2) == '0)) |-> product == '0);

    // R8: sign of a product of two nonzero operands.
    a_r8_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(opnd_a, 2) != '0 && $past(opnd_b, 2) != '0)
        |-> product[W-1] == ($past(opnd_a[N-1], 2) ^ $past(opnd_b[N-1], 2)));

endmodule

bind booth_csa_mult booth_csa_mult_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .product(product)
);

// File: tb/booth_csa_mult_test.sv
// Scoreboard bench: driver tasks queue expected products, monitors pop
// and compare them when each result is due at the ports.
module booth_csa_mult_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int W  = 2 * N;
    localparam int NS = 5;
    localparam int WS = 2 * NS;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a_in  = '0;
    logic [N-1:0]  b_in  = '0;
    logic [NS-1:0] a5    = '0;
    logic [NS-1:0] b5    = '0;
    logic [W-1:0]  prod;
    logic [WS-1:0] prod5;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_csa_mult #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(a_in), .opnd_b(b_in), .product(prod));

    booth_csa_mult #(.N(NS)) uut_odd (
        .clk(clk), .rst_n(rst_n), .opnd_a(a5), .opnd_b(b5), .product(prod5));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct { logic [W-1:0]  exp; int due; string req; } item_t;
    typedef struct { logic [WS-1:0] exp; int due; string req; } item5_t;
    item_t  q[$];
    item5_t q5[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p[W-1:0];
    endfunction

    function automatic logic [WS-1:0] ref_mul5(input logic [NS-1:0] x, input logic [NS-1:0] y);
        int p;
        p = int'($signed(x)) * int'($signed(y));
        return p[WS-1:0];
    endfunction

    task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input string req);
        item_t it;
        @(negedge clk);
        a_in = x;
        b_in = y;
        it.exp = ref_mul(x, y);
        it.due = cyc + 2;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic drive5(input logic [NS-1:0] x, input logic [NS-1:0] y);
        item5_t it;
        @(negedge clk);
        a5 = x;
        b5 = y;
        it.exp = ref_mul5(x, y);
        it.due = cyc + 2;
        it.req = "R9 odd width";
        q5.push_back(it);
    endtask

    // Monitor for the wide instance.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            check(prod == it.exp, it.req, 64'(prod), 64'(it.exp));
        end
    end

    // Monitor for the odd-width instance.
    always @(negedge clk) begin
        if (q5.size() > 0 && q5[0].due <= cyc) begin
            item5_t it;
            it = q5.pop_front();
            check(prod5 == it.exp, it.req, 64'(prod5), 64'(it.exp));
        end
    end

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=complete");
        finish_run();
    end

    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MINUS1   = '1;

    initial begin
        // R1: reset state with nonzero operands applied.
        a_in = 16'h1234;
        b_in = 16'h0F0F;
        a5   = 5'h0B;
        b5   = 5'h07;
        repeat (3) @(negedge clk);
        check(prod == '0, "R1 reset product", 64'(prod), 64'd0);
        check(prod5 == '0, "R1 reset odd product", 64'(prod5), 64'd0);
        rst_n = 1'b1;

        fork
            begin
                // R4 corners.
                drive(MOST_NEG, MOST_NEG, "R4 most negative squared");
                check(ref_mul(MOST_NEG, MOST_NEG) == 32'h4000_0000, "R4 reference",
                      64'(ref_mul(MOST_NEG, MOST_NEG)), 64'h4000_0000);
                // R5 zero.
                drive('0, 16'h7ABC, "R5 zero times value");
                drive(16'h8001, '0, "R5 value times zero");
                drive('0, '0, "R5 zero times zero");
                // R6 minus one.
                drive(MINUS1, MOST_NEG, "R6 minus one times most negative");
                drive(16'h1357, MINUS1, "R6 value times minus one");
                drive(MINUS1, MINUS1, "R6 minus one squared");
                // R7 code-covering multiplier patterns.
                drive(16'h6D2B, 16'h5555, "R7 pattern 5555");
                drive(16'h6D2B, 16'hAAAA, "R7 pattern AAAA");
                drive(16'hB3C1, 16'h3333, "R7 pattern 3333");
                drive(16'hB3C1, 16'hCCCC, "R7 pattern CCCC");
                drive(16'h7FFF, 16'h7FFF, "R7 pattern 7FFF");
                drive(16'h0101, MOST_NEG, "R7 pattern 8000");
                // R8 sign combinations.
                drive(16'h0003, 16'hFFFB, "R8 positive times negative");
                drive(16'hFFF0, 16'hFF00, "R8 negative times negative");
                // R2 and R3: back-to-back random pairs.
                for (int i = 0; i < 400; i++) begin
                    drive(N'($urandom), N'($urandom), "R2 R3 random back-to-back");
                end
                // R3 repeated pair held across cycles.
                for (int i = 0; i < 4; i++) begin
                    drive(16'h2468, 16'hFACE, "R3 held pair");
                end
            end
            begin
                // R9: exhaustive odd width.
                for (int x = 0; x < 32; x++) begin
                    for (int y = 0; y < 32; y++) begin
                        drive5(NS'(x), NS'(y));
                    end
                end
            end
        join

        repeat (4) @(negedge clk);

        // R1: mid-run reset clears product and operand registers.
        a_in  = 16'h0007;
        b_in  = 16'h0009;
        rst_n = 1'b0;
        @(negedge clk);
        check(prod == '0, "R1 mid-run reset product", 64'(prod), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(prod == '0, "R1 cleared operands multiplied", 64'(prod), 64'd0);
        @(negedge clk);
        check(prod == 32'd63, "R1 R2 first product after reset", 64'(prod), 64'd63);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule